// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of a parallel NOR flash device that is driven by multi-write unlock sequences. A client hands it one request at a time: program a word, erase a sector, erase the whole chip, or fetch the two identification words. The block turns the request into the matching series of bus writes, each framed by chip-enable and write-enable strobes. After a program or erase it polls the device over the same bus until the device reports that it has finished, and then it returns a one-cycle response.

Requests use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after the response, so a client that keeps `req_valid` high in the meantime only waits and does not start a second operation. The response is a one-cycle pulse with no back-pressure. The client must be ready to take it when it comes.

All electrical timing is expressed as clock-cycle counts: strobe width, recovery gap, read access time, the settle time after leaving ID mode, and the two polling time limits. Completion is detected in one of two ways. In data polling the block watches bit 7 until it shows the true value. In toggle polling it watches bit 6 until two successive reads return the same value.

Top module: `flash_cmd_engine`

## Requirements
- R1: Request code 0 (program) produces exactly four bus writes, in order: 0x00AA at 0x5555, 0x0055 at 0x2AAA, 0x00A0 at 0x5555, then `req_data` at `req_addr`.
- R2: Request code 2 (chip erase) produces exactly six bus writes, in order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555.
- R3: Request code 1 (sector erase) produces the same first five writes as R2, and its sixth write is 0x0030 at `req_addr`.
- R4: In every bus write, CE and WE are both low for exactly WE_PULSE cycles with OE high. Address and write data do not change while WE is low. WE stays high for at least GAP_CYCLES cycles between two writes.
- R5: With `poll_toggle`=0, the block reads the target address after the last write, one read at a time. It finishes on the first read whose bit 7 equals the true bit 7. For a program this is `req_data[7]`. For an erase it is 1, because erased data reads as 0xFFFF.
- R6: With `poll_toggle`=1, the block reads the target address repeatedly. It finishes on the first read whose bit 6 equals bit 6 of the read just before it.
- R7: Request code 3 (read ID) writes 0xAA@0x5555, 0x55@0x2AAA and 0x90@0x5555. It then reads address 0 into `rsp_id0` and address 1 into `rsp_id1`, and writes 0xAA@0x5555, 0x55@0x2AAA and 0xF0@0x5555. It responds no sooner than ID_EXIT_WAIT cycles after the last write.
- R8: If polling has run for PROG_TIMEOUT cycles (program) or ERASE_TIMEOUT cycles (erase) and a read still shows the device busy, the block pulses `rsp_valid` with `rsp_error`=1 and returns to accepting requests.
- R9: `req_ready` is low from the cycle after acceptance until the response cycle, and high in the cycle after it. `rsp_valid` lasts one cycle. While `req_ready` is low, `req_valid` causes no bus activity.
- R10: During reset and immediately after it, CE, WE and OE are high, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 read ID |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Word to program |
| poll_toggle | input | 1 | 0 selects data polling, 1 selects toggle polling |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Completion was a timeout (valid with rsp_valid) |
| rsp_id0 | output | DW | Word read from address 0 by the last ID request |
| rsp_id1 | output | DW | Word read from address 1 by the last ID request |
| fl_addr | output | AW | Flash address bus |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The bench drives both polarities of the programmed bit 7. A controller that compared against a fixed value, or against the complement, would stop polling too early or would run into the timeout. In toggle mode it counts the exact number of reads the bench itself predicts, including a device that is already idle on the first read. A controller that stopped after a single read, or that compared bit 7, would show a different read count. It also lets both time limits run out on a device that never finishes. It keeps `req_valid` high during a busy operation, which would show up as extra writes in the log. Finally it checks the ID words and the settle delay after leaving ID mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_ID   = 2'd3
  } fc_op_e;

  typedef enum logic [2:0] {
    K_WR, K_RD, K_POLL, K_WAIT, K_END
  } fc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_STEP, S_WLOW, S_WHIGH, S_RLOW, S_RHIGH, S_WAIT, S_RSP
  } fc_state_e;
endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_cmd_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input  fc_op_e         op,
  input  logic [3:0]     step,
  input  logic [AW-1:0]  tgt_addr,
  input  logic [DW-1:0]  tgt_data,
  output fc_kind_e       kind,
  output logic [AW-1:0]  addr,
  output logic [DW-1:0]  data,
  output logic           slot
);
  localparam logic [AW-1:0] UL_A = AW'(15'h5555);
  localparam logic [AW-1:0] UL_B = AW'(15'h2AAA);

  // Unlock prefix shared by every request: steps 0,1 and erase steps 3,4
  always_comb begin
    kind = K_END;
    addr = '0;
    data = '0;
    slot = 1'b0;
    unique case (op)
      OP_PROG: begin
        unique case (step)
          4'd0: begin kind = K_WR; addr = UL_A; data = DW'(8'hAA); end
          4'd1: begin kind = K_WR; addr = UL_B; data = DW'(8'h55); end
          4'd2: begin kind = K_WR; addr = UL_A; data = DW'(8'hA0); end
          4'd3: begin kind = K_WR; addr = tgt_addr; data = tgt_data; end
          4'd4: kind = K_POLL;
          default: kind = K_END;
        endcase
      end
      OP_SECT, OP_CHIP: begin
        unique case (step)
          4'd0, 4'd3: begin kind = K_WR; addr = UL_A; data = DW'(8'hAA); end
          4'd1, 4'd4: begin kind = K_WR; addr = UL_B; data = DW'(8'h55); end
          4'd2: begin kind = K_WR; addr = UL_A; data = DW'(8'h80); end
          4'd5: begin
            kind = K_WR;
            addr = (op == OP_CHIP) ? UL_A : tgt_addr;
            data = (op == OP_CHIP) ? DW'(8'h10) : DW'(8'h30);
          end
          4'd6: kind = K_POLL;
          default: kind = K_END;
        endcase
      end
      default: begin
        unique case (step)
          4'd0, 4'd5: begin kind = K_WR; addr = UL_A; data = DW'(8'hAA); end
          4'd1, 4'd6: begin kind = K_WR; addr = UL_B; data = DW'(8'h55); end
          4'd2: begin kind = K_WR; addr = UL_A; data = DW'(8'h90); end
          4'd3: begin kind = K_RD; addr = '0; end
          4'd4: begin kind = K_RD; addr = AW'(1); slot = 1'b1; end
          4'd7: begin kind = K_WR; addr = UL_A; data = DW'(8'hF0); end
          4'd8: kind = K_WAIT;
          default: kind = K_END;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval #(
  parameter int DW = 16
) (
  input  logic          toggle_mode,
  input  logic [DW-1:0] rd,
  input  logic          want7,
  input  logic          prev6,
  input  logic          have_prev,
  output logic          finished
);
  always_comb begin
    if (toggle_mode) finished = have_prev && (rd[6] == prev6);
    else             finished = (rd[7] == want7);
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int AW            = 17,
  parameter int DW            = 16,
  parameter int WE_PULSE      = 3,
  parameter int GAP_CYCLES    = 2,
  parameter int RD_CYCLES     = 2,
  parameter int PROG_TIMEOUT  = 5000,
  parameter int ERASE_TIMEOUT = 20000000,
  parameter int ID_EXIT_WAIT  = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          poll_toggle,
  output logic          rsp_valid,
  output logic          rsp_error,
  output logic [DW-1:0] rsp_id0,
  output logic [DW-1:0] rsp_id1,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int M1   = (WE_PULSE > GAP_CYCLES) ? WE_PULSE : GAP_CYCLES;
  localparam int M2   = (RD_CYCLES > M1) ? RD_CYCLES : M1;
  localparam int CMAX = (ID_EXIT_WAIT > M2) ? ID_EXIT_WAIT : M2;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int TMAX = (ERASE_TIMEOUT > PROG_TIMEOUT) ? ERASE_TIMEOUT : PROG_TIMEOUT;
  localparam int TW   = $clog2(TMAX + 1);

  fc_state_e     st_q;
  fc_op_e        op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          mode_q;
  logic [3:0]    step_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] poll_cnt_q;
  logic          is_poll_q, slot_q, prev6_q, have_prev_q, err_q;

  fc_kind_e      r_kind;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_data;
  logic          r_slot;
  logic          poll_fin;
  logic [TW-1:0] limit;

  flash_cmd_rom #(.AW(AW), .DW(DW)) u_rom (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .kind(r_kind), .addr(r_addr), .data(r_data), .slot(r_slot)
  );

  flash_poll_eval #(.DW(DW)) u_eval (
    .toggle_mode(mode_q), .rd(fl_rdata),
    .want7((op_q == OP_PROG) ? data_q[7] : 1'b1),
    .prev6(prev6_q), .have_prev(have_prev_q), .finished(poll_fin)
  );

  assign limit = (op_q == OP_PROG) ? TW'(PROG_TIMEOUT) : TW'(ERASE_TIMEOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; op_q <= OP_PROG; addr_q <= '0; data_q <= '0;
      mode_q <= 1'b0; step_q <= '0; cnt_q <= '0; poll_cnt_q <= '0;
      is_poll_q <= 1'b0; slot_q <= 1'b0; prev6_q <= 1'b0;
      have_prev_q <= 1'b0; err_q <= 1'b0;
      rsp_id0 <= '0; rsp_id1 <= '0; fl_addr <= '0; fl_wdata <= '0;
    end else begin
      if (is_poll_q && poll_cnt_q != '1) poll_cnt_q <= poll_cnt_q + 1'b1;
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          op_q <= fc_op_e'(req_op); addr_q <= req_addr; data_q <= req_data;
          mode_q <= poll_toggle; step_q <= '0; err_q <= 1'b0;
          have_prev_q <= 1'b0; is_poll_q <= 1'b0; poll_cnt_q <= '0;
          st_q <= S_STEP;
        end
        S_STEP: begin
          unique case (r_kind)
            K_WR: begin
              fl_addr <= r_addr; fl_wdata <= r_data;
              cnt_q <= CW'(WE_PULSE - 1); st_q <= S_WLOW;
            end
            K_RD: begin
              fl_addr <= r_addr; slot_q <= r_slot; is_poll_q <= 1'b0;
              cnt_q <= CW'(RD_CYCLES - 1); st_q <= S_RLOW;
            end
            K_POLL: begin
              fl_addr <= addr_q; is_poll_q <= 1'b1;
              cnt_q <= CW'(RD_CYCLES - 1); st_q <= S_RLOW;
            end
            K_WAIT: begin cnt_q <= CW'(ID_EXIT_WAIT - 1); st_q <= S_WAIT; end
            default: st_q <= S_RSP;
          endcase
        end
        S_WLOW: if (cnt_q == '0) begin
          cnt_q <= CW'(GAP_CYCLES - 1); st_q <= S_WHIGH;
        end else cnt_q <= cnt_q - 1'b1;
        S_WHIGH: if (cnt_q == '0) begin
          step_q <= step_q + 1'b1; st_q <= S_STEP;
        end else cnt_q <= cnt_q - 1'b1;
        S_RLOW: if (cnt_q == '0) begin
          cnt_q <= CW'(GAP_CYCLES - 1);
          if (!is_poll_q) begin
            if (slot_q) rsp_id1 <= fl_rdata;
            else        rsp_id0 <= fl_rdata;
            step_q <= step_q + 1'b1; st_q <= S_RHIGH;
          end else begin
            prev6_q <= fl_rdata[6]; have_prev_q <= 1'b1;
            if (poll_fin) begin
              step_q <= step_q + 1'b1; st_q <= S_RHIGH;
            end else if (poll_cnt_q >= limit) begin
              err_q <= 1'b1; st_q <= S_RSP;
            end else st_q <= S_RHIGH;
          end
        end else cnt_q <= cnt_q - 1'b1;
        S_RHIGH: if (cnt_q == '0) st_q <= S_STEP;
                 else cnt_q <= cnt_q - 1'b1;
        S_WAIT: if (cnt_q == '0) begin
          step_q <= step_q + 1'b1; st_q <= S_STEP;
        end else cnt_q <= cnt_q - 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_RSP);
  assign rsp_error = rsp_valid && err_q;
  assign fl_we_n   = (st_q != S_WLOW);
  assign fl_oe_n   = (st_q != S_RLOW);
  assign fl_ce_n   = !((st_q == S_WLOW) || (st_q == S_RLOW));
endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk #(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_error,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_wdata,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n
);
  p_we_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_oe_n));

  p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));

  p_rsp_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_err_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> rsp_valid);

  p_quiet_at_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n));
endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_error(rsp_error), .fl_addr(fl_addr),
  .fl_wdata(fl_wdata), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/flash_cmd_engine_tb.sv
`timescale 1ns/1ps
module flash_cmd_engine_tb;
  localparam int AW = 17, DW = 16;
  localparam int WEP = 3, GAP = 2, RDC = 2, PTO = 300, ETO = 900, IDW = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, poll_toggle = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, rsp_valid, rsp_error, fl_ce_n, fl_we_n, fl_oe_n;
  logic [DW-1:0] rsp_id0, rsp_id1, fl_wdata, fl_rdata;
  logic [AW-1:0] fl_addr;

  always #5 clk = ~clk;

  flash_cmd_engine #(.AW(AW), .DW(DW), .WE_PULSE(WEP), .GAP_CYCLES(GAP),
    .RD_CYCLES(RDC), .PROG_TIMEOUT(PTO), .ERASE_TIMEOUT(ETO),
    .ID_EXIT_WAIT(IDW)) u_dut (.*);

  // device model
  int reads_left = 0;
  bit tog = 1'b0;
  bit id_en = 1'b0;
  logic [DW-1:0] true_data = 16'hFFFF, id0v = '0, id1v = '0;
  assign fl_rdata = (fl_oe_n || fl_ce_n) ? '0 :
                    (id_en && fl_addr == 0) ? id0v :
                    (id_en && fl_addr == 1) ? id1v :
                    (reads_left > 0) ? {true_data[15:8], ~true_data[7], tog, true_data[5:0]} :
                    true_data;

  // bus monitor
  int total = 0, bad = 0, cyc = 0;
  int wr_n = 0, rd_n = 0, viol = 0, we_low = 0, we_high = 0, last_rise = 0;
  logic [AW-1:0] wa [16];
  logic [DW-1:0] wd [16];
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [AW-1:0] prev_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!fl_we_n) begin
        we_low++;
        if (fl_ce_n || !fl_oe_n) viol++;
        if (!prev_we && fl_addr != prev_addr) viol++;
        if (prev_we && wr_n > 0 && we_high < GAP) viol++;
      end
      if (fl_we_n && !prev_we) begin
        if (we_low != WEP) viol++;
        if (wr_n < 16) begin wa[wr_n] = fl_addr; wd[wr_n] = fl_wdata; end
        wr_n++; we_low = 0; we_high = 0; last_rise = cyc;
      end
      if (fl_we_n) we_high++;
      if (fl_oe_n && !prev_oe) begin
        rd_n++;
        if (reads_left > 0) begin reads_left--; tog = ~tog; end
      end
    end
    prev_we = fl_we_n; prev_oe = fl_oe_n; prev_addr = fl_addr;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_count(input logic [1:0] op);
    return (op == 2'd0) ? 4 : 6;
  endfunction

  function automatic logic [AW+DW-1:0] exp_wr(input logic [1:0] op, input int k,
      input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [AW-1:0] A5, A2;
    A5 = AW'(15'h5555); A2 = AW'(15'h2AAA);
    case (op)
      2'd0: case (k)
        0: return {A5, 16'h00AA}; 1: return {A2, 16'h0055};
        2: return {A5, 16'h00A0}; default: return {a, d};
      endcase
      2'd3: case (k)
        0, 3: return {A5, 16'h00AA}; 1, 4: return {A2, 16'h0055};
        2: return {A5, 16'h0090}; default: return {A5, 16'h00F0};
      endcase
      default: case (k)
        0, 3: return {A5, 16'h00AA}; 1, 4: return {A2, 16'h0055};
        2: return {A5, 16'h0080};
        default: return (op == 2'd2) ? {A5, 16'h0010} : {a, 16'h0030};
      endcase
    endcase
  endfunction

  // number of poll reads a toggle-mode controller needs
  function automatic int exp_tog_reads(input int n, input bit t0, input bit true6);
    bit prev, v;
    prev = 1'b0;
    for (int k = 1; k < 1000; k++) begin
      v = (k <= n) ? (t0 ^ bit'((k - 1) & 1)) : true6;
      if (k >= 2 && v == prev) return k;
      prev = v;
    end
    return -1;
  endfunction

  int op_cycles;
  bit op_err, seen_ready;

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
      input logic [DW-1:0] d, input bit mode, input bit hold);
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    wr_n = 0; rd_n = 0; viol = 0; seen_ready = 0;
    req_op = op; req_addr = a; req_data = d; poll_toggle = mode; req_valid = 1'b1;
    @(negedge clk); #1;
    if (!hold) req_valid = 1'b0;
    op_cycles = 1;
    for (int i = 0; i < 20000 && !rsp_valid; i++) begin
      if (req_ready) seen_ready = 1;
      @(negedge clk); #1;
      op_cycles++;
    end
    req_valid = 1'b0;
    op_err = rsp_error;
  endtask

  task automatic check_writes(input logic [1:0] op, input logic [AW-1:0] a,
      input logic [DW-1:0] d, input string tag);
    int mism;
    mism = 0;
    chk(wr_n == exp_count(op), {tag, " write count"}, wr_n, exp_count(op));
    for (int k = 0; k < exp_count(op) && k < 16; k++)
      if ({wa[k], wd[k]} != exp_wr(op, k, a, d)) mism++;
    chk(mism == 0, {tag, " write content"}, mism, 0);
  endtask

  task automatic prep(input int busy, input logic [DW-1:0] td);
    reads_left = busy; true_data = td;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n_exp;
    logic [1:0] op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    bit m;
    int busy;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    #1;
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R10 strobes in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(req_ready && !rsp_valid, "R10 handshake in reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(fl_ce_n && fl_we_n && fl_oe_n && req_ready && !rsp_valid, "R10 after reset",
        {fl_ce_n, fl_we_n, fl_oe_n, req_ready, rsp_valid}, 5'b11110);

    // R1 R5: program, data polling, bit7 = 0
    prep(3, 16'h1234);
    run_op(2'd0, 17'h0_0456, 16'h1234, 1'b0, 1'b0);
    check_writes(2'd0, 17'h0_0456, 16'h1234, "R1");
    chk(viol == 0, "R4 strobe timing", viol, 0);
    chk(rd_n == 4 && !op_err, "R5 data poll bit7=0", rd_n, 4);
    chk(!seen_ready, "R9 ready low while busy", seen_ready, 0);

    // R5: bit7 = 1, device already idle
    prep(0, 16'h00B5);
    run_op(2'd0, 17'h1_0002, 16'h00B5, 1'b0, 1'b0);
    chk(rd_n == 1 && !op_err, "R5 data poll bit7=1 idle", rd_n, 1);

    // R6: program, toggle polling
    prep(4, 16'h5A3C);
    n_exp = exp_tog_reads(4, tog, 1'b0);
    run_op(2'd0, 17'h0_7777, 16'h5A3C, 1'b1, 1'b0);
    chk(rd_n == n_exp && !op_err, "R6 toggle poll busy", rd_n, n_exp);

    // R6: toggle polling on an idle device needs two reads
    prep(0, 16'h0040);
    run_op(2'd0, 17'h0_0100, 16'h0040, 1'b1, 1'b0);
    chk(rd_n == 2, "R6 toggle poll idle", rd_n, 2);

    // R2 R5: chip erase, data polling on erased value
    prep(2, 16'hFFFF);
    run_op(2'd2, 17'h0_0003, 16'h0000, 1'b0, 1'b0);
    check_writes(2'd2, 17'h0_0003, 16'h0000, "R2");
    chk(rd_n == 3 && !op_err, "R5 erase data poll", rd_n, 3);

    // R3 R6: sector erase, toggle polling
    prep(3, 16'hFFFF);
    n_exp = exp_tog_reads(3, tog, 1'b1);
    run_op(2'd1, 17'h1_A345, 16'h0000, 1'b1, 1'b0);
    check_writes(2'd1, 17'h1_A345, 16'h0000, "R3");
    chk(rd_n == n_exp && !op_err, "R6 sector erase toggle", rd_n, n_exp);
    chk(viol == 0, "R4 strobe timing erase", viol, 0);

    // R7: ID read
    id0v = 16'($urandom); id1v = 16'($urandom); id_en = 1'b1;
    prep(0, 16'hFFFF);
    run_op(2'd3, 17'h0_0000, 16'h0000, 1'b0, 1'b0);
    id_en = 1'b0;
    check_writes(2'd3, 17'h0, 16'h0, "R7");
    chk(rd_n == 2, "R7 id read count", rd_n, 2);
    chk(rsp_id0 == id0v && rsp_id1 == id1v, "R7 id words", {rsp_id0, rsp_id1}, {id0v, id1v});
    chk((cyc - last_rise) >= IDW && (cyc - last_rise) <= IDW + GAP + 4,
        "R7 exit settle", cyc - last_rise, IDW);

    // R8: program timeout, erase timeout
    prep(1000000, 16'h0011);
    run_op(2'd0, 17'h0_0900, 16'h0011, 1'b0, 1'b0);
    chk(op_err && op_cycles >= PTO, "R8 program timeout", {op_err, op_cycles}, PTO);
    @(negedge clk); #1;
    chk(req_ready, "R8 ready after timeout", req_ready, 1);
    prep(1000000, 16'hFFFF);
    run_op(2'd2, 17'h0_0900, 16'h0000, 1'b1, 1'b0);
    chk(op_err && op_cycles >= ETO, "R8 erase timeout", {op_err, op_cycles}, ETO);
    prep(0, 16'hFFFF);

    // R9: request held high during a busy operation
    prep(2, 16'h0F0F);
    run_op(2'd0, 17'h0_0222, 16'h0F0F, 1'b0, 1'b1);
    chk(wr_n == 4 && !seen_ready, "R9 held valid ignored", wr_n, 4);
    repeat (3) @(negedge clk);
    #1;
    chk(wr_n == 4 && req_ready, "R9 no restart", wr_n, 4);

    // random mix
    for (int it = 0; it < 12; it++) begin
      op = 2'($urandom_range(0, 2));
      a = AW'($urandom_range(2, (1 << AW) - 1));
      d = 16'($urandom);
      m = 1'($urandom);
      busy = $urandom_range(0, 6);
      prep(busy, (op == 2'd0) ? d : 16'hFFFF);
      n_exp = m ? exp_tog_reads(busy, tog, (op == 2'd0) ? d[6] : 1'b1) : busy + 1;
      run_op(op, a, d, m, 1'b0);
      check_writes(op, a, d, (op == 2'd0) ? "R1 rnd" : (op == 2'd1) ? "R3 rnd" : "R2 rnd");
      chk(rd_n == n_exp && !op_err, m ? "R6 rnd polls" : "R5 rnd polls", rd_n, n_exp);
      chk(viol == 0, "R4 rnd strobes", viol, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule